// File: doc/BRIEF.md
# PCIe Transaction-Layer Traffic Monitor

This block listens passively to both directions of a wide PCIe transaction-layer stream and gathers activity figures over a one-second window. Each direction has its own valid, ready and last signals. The TLP kind and payload length are decoded elsewhere and presented with the stream. For each direction the block counts accepted beats and the payload of memory-write and completion TLPs. It also keeps, once, the initial flow-control credits that the link partner advertises.

A one-second tick closes the current window. At that tick the accumulated figures move into read-only snapshot registers and a fresh window begins. Software reads the snapshots through a combinational register read port. Each byte-count register carries a rolling two-bit sample number in its low bits. Software can compare that number between two reads to tell a new window from one it has already read.

Top module: `tl_traffic_mon`

## Requirements
- R1: A beat of a direction is counted only in a cycle where that direction's valid and ready are both high. Every accepted beat counts, header beats included. Upstream beats read at byte offset 0x00 and downstream beats at 0x04.
- R2: Snapshot registers change only on a cycle with `tick_1s` high. At that cycle they take the figures of the window that is closing, and the accumulators restart. A beat accepted in the tick cycle belongs to the new window.
- R3: The kind code is 1 for a memory write, 2 for a completion with data, and 0 or 3 for anything else. Kind and length (in 4-byte units) are taken only from the first accepted beat of a TLP, which is the first beat after reset or after a beat with last high. Upstream memory-write payload reads at offset 0x08, bits [31:2], in 4-byte units.
- R4: Upstream completion payload (0x0C), downstream memory-write payload (0x10) and downstream completion payload (0x14) are accumulated separately, in the same format as R3.
- R5: Bits [1:0] of every byte-count register hold a sample number that is 0 after reset and advances by one at each tick, wrapping from 3 to 0.
- R6: A byte accumulator that would pass its largest value within a window stays at that value. The next window starts again from zero.
- R7: On the first credit-initialisation strobe after reset, the block captures the credits: non-posted header (0x18, bits [7:0]), posted data (0x1C, bits [11:0]), completion header (0x20, bits [7:0]) and completion data (0x24, bits [11:0]). Later strobes leave these fields unchanged.
- R8: All registers read zero after reset. Unused bits, addresses at 0x28 and above, and addresses that are not 4-byte aligned read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse closing the measurement window |
| up_valid | input | 1 | Upstream stream valid |
| up_ready | input | 1 | Upstream stream ready |
| up_last | input | 1 | Upstream last beat of TLP |
| up_kind | input | 2 | Upstream decoded TLP kind |
| up_len | input | LEN_W | Upstream payload length in 4-byte units |
| dn_valid | input | 1 | Downstream stream valid |
| dn_ready | input | 1 | Downstream stream ready |
| dn_last | input | 1 | Downstream last beat of TLP |
| dn_kind | input | 2 | Downstream decoded TLP kind |
| dn_len | input | LEN_W | Downstream payload length in 4-byte units |
| cr_init | input | 1 | Credit-initialisation strobe |
| cr_nph | input | HCR_W | Advertised non-posted header credits |
| cr_pd | input | DCR_W | Advertised posted data credits |
| cr_cplh | input | HCR_W | Advertised completion header credits |
| cr_cpld | input | DCR_W | Advertised completion data credits |
| rd_addr | input | ADDR_W | Register byte address |
| rd_data | output | 32 | Register read data |

## Verification
The assertions check several properties on every cycle. Snapshots hold steady between ticks. The sample number steps by exactly one per tick and appears in the low bits of a byte-count read. Credits cannot move once captured, and unmapped or misaligned addresses return zero. Other behaviour needs the bench's directed scenarios. These include which beats count as accepted, taking kind and length only from the first beat of a TLP, splitting traffic into four payload totals, assigning a tick-cycle beat to the new window, saturation and restart in a narrow-field instance, and ignoring a second credit strobe.

// File: rtl/tlmon_pkg.sv
`timescale 1ns/1ps
package tlmon_pkg;
   localparam int REG_W   = 32;
   localparam int SMP_W   = 2;
   localparam int NUM_DIR = 2;

   typedef enum logic [1:0] {
      TK_OTHER = 2'd0,
      TK_MWR   = 2'd1,
      TK_CPL   = 2'd2,
      TK_RSVD  = 2'd3
   } tlp_kind_e;

   // word index of each register; byte offset is index * 4
   typedef enum logic [3:0] {
      RG_UP_BEAT = 4'd0,
      RG_DN_BEAT = 4'd1,
      RG_UP_WR   = 4'd2,
      RG_UP_CPL  = 4'd3,
      RG_DN_WR   = 4'd4,
      RG_DN_CPL  = 4'd5,
      RG_CR_NPH  = 4'd6,
      RG_CR_PD   = 4'd7,
      RG_CR_CPLH = 4'd8,
      RG_CR_CPLD = 4'd9
   } reg_idx_e;

   localparam int NUM_REGS = 10;
   localparam int IDX_W    = $clog2(NUM_REGS);
endpackage

// File: rtl/tlmon_win_acc.sv
`timescale 1ns/1ps
// Saturating window accumulator with snapshot on tick.
module tlmon_win_acc #(
   parameter int W     = 32,
   parameter int INC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     snap
);
   localparam int SUM_W = W + 1;

   generate
      if (INC_W > W) begin : g_bad_inc
         $error("tlmon_win_acc: increment wider than accumulator");
      end
   endgenerate

   logic [W-1:0]     acc;
   logic [SUM_W-1:0] sum;
   logic [W-1:0]     acc_nxt;

   always_comb begin
      sum     = {1'b0, acc} + SUM_W'(inc);
      acc_nxt = sum[W] ? '1 : sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         snap <= '0;
      end else if (tick) begin
         snap <= acc;
         acc  <= inc_en ? W'(inc) : '0;
      end else if (inc_en) begin
         acc  <= acc_nxt;
      end
   end
endmodule

// File: rtl/tlmon_dir_snoop.sv
`timescale 1ns/1ps
// One direction: beat counting, start-of-TLP tracking, payload split by kind.
module tlmon_dir_snoop
   import tlmon_pkg::*;
#(
   parameter int BEAT_W = 32,
   parameter int BYTE_W = 30,
   parameter int LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              valid,
   input  logic              ready,
   input  logic              last,
   input  logic [1:0]        kind,
   input  logic [LEN_W-1:0]  len,
   output logic [BEAT_W-1:0] beat_snap,
   output logic [BYTE_W-1:0] wr_snap,
   output logic [BYTE_W-1:0] cpl_snap
);
   logic fire;
   logic mid_pkt;
   logic head;
   logic wr_hit;
   logic cpl_hit;

   assign fire    = valid & ready;
   assign head    = fire & ~mid_pkt;
   assign wr_hit  = head && (tlp_kind_e'(kind) == TK_MWR);
   assign cpl_hit = head && (tlp_kind_e'(kind) == TK_CPL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mid_pkt <= 1'b0;
      else if (fire) mid_pkt <= ~last;
   end

   tlmon_win_acc #(.W(BEAT_W), .INC_W(1)) u_beat (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .inc_en(fire), .inc(1'b1), .snap(beat_snap)
   );

   tlmon_win_acc #(.W(BYTE_W), .INC_W(LEN_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .inc_en(wr_hit), .inc(len), .snap(wr_snap)
   );

   tlmon_win_acc #(.W(BYTE_W), .INC_W(LEN_W)) u_cpl (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .inc_en(cpl_hit), .inc(len), .snap(cpl_snap)
   );
endmodule

// File: rtl/tlmon_credit_cap.sv
`timescale 1ns/1ps
// First-strobe-only capture of advertised flow-control credits.
module tlmon_credit_cap #(
   parameter int HCR_W = 8,
   parameter int DCR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic [HCR_W-1:0] nph,
   input  logic [DCR_W-1:0] pd,
   input  logic [HCR_W-1:0] cplh,
   input  logic [DCR_W-1:0] cpld,
   output logic [HCR_W-1:0] nph_q,
   output logic [DCR_W-1:0] pd_q,
   output logic [HCR_W-1:0] cplh_q,
   output logic [DCR_W-1:0] cpld_q,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nph_q  <= '0;
         pd_q   <= '0;
         cplh_q <= '0;
         cpld_q <= '0;
         done   <= 1'b0;
      end else if (init && !done) begin
         nph_q  <= nph;
         pd_q   <= pd;
         cplh_q <= cplh;
         cpld_q <= cpld;
         done   <= 1'b1;
      end
   end
endmodule

// File: rtl/tl_traffic_mon.sv
`timescale 1ns/1ps
module tl_traffic_mon
   import tlmon_pkg::*;
#(
   parameter int BEAT_W = 32,
   parameter int BYTE_W = 30,
   parameter int LEN_W  = 11,
   parameter int HCR_W  = 8,
   parameter int DCR_W  = 12,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1s,
   input  logic              up_valid,
   input  logic              up_ready,
   input  logic              up_last,
   input  logic [1:0]        up_kind,
   input  logic [LEN_W-1:0]  up_len,
   input  logic              dn_valid,
   input  logic              dn_ready,
   input  logic              dn_last,
   input  logic [1:0]        dn_kind,
   input  logic [LEN_W-1:0]  dn_len,
   input  logic              cr_init,
   input  logic [HCR_W-1:0]  cr_nph,
   input  logic [DCR_W-1:0]  cr_pd,
   input  logic [HCR_W-1:0]  cr_cplh,
   input  logic [DCR_W-1:0]  cr_cpld,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data
);
   localparam int FIELD_W = REG_W - SMP_W;

   generate
      if (BEAT_W < 1 || BEAT_W > REG_W) begin : g_bad_beat
         $error("tl_traffic_mon: BEAT_W out of range");
      end
      if (BYTE_W < 1 || BYTE_W > FIELD_W) begin : g_bad_byte
         $error("tl_traffic_mon: BYTE_W out of range");
      end
      if (LEN_W > BYTE_W) begin : g_bad_len
         $error("tl_traffic_mon: LEN_W wider than BYTE_W");
      end
      if (HCR_W > REG_W || DCR_W > REG_W) begin : g_bad_cr
         $error("tl_traffic_mon: credit width exceeds register");
      end
      if (ADDR_W < IDX_W + 3) begin : g_bad_addr
         $error("tl_traffic_mon: ADDR_W too small for register map");
      end
   endgenerate

   // direction 0 = upstream, 1 = downstream
   logic [NUM_DIR-1:0]            d_valid, d_ready, d_last;
   logic [NUM_DIR-1:0][1:0]       d_kind;
   logic [NUM_DIR-1:0][LEN_W-1:0] d_len;
   logic [NUM_DIR-1:0][BEAT_W-1:0] beat_snap;
   logic [NUM_DIR-1:0][BYTE_W-1:0] wr_snap;
   logic [NUM_DIR-1:0][BYTE_W-1:0] cpl_snap;

   assign d_valid = {dn_valid, up_valid};
   assign d_ready = {dn_ready, up_ready};
   assign d_last  = {dn_last,  up_last};
   assign d_kind  = {dn_kind,  up_kind};
   assign d_len   = {dn_len,   up_len};

   generate
      for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
         tlmon_dir_snoop #(.BEAT_W(BEAT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_dir (
            .clk(clk), .rst_n(rst_n), .tick(tick_1s),
            .valid(d_valid[d]), .ready(d_ready[d]), .last(d_last[d]),
            .kind(d_kind[d]), .len(d_len[d]),
            .beat_snap(beat_snap[d]), .wr_snap(wr_snap[d]), .cpl_snap(cpl_snap[d])
         );
      end
   endgenerate

   logic [SMP_W-1:0] smp;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       smp <= '0;
      else if (tick_1s) smp <= smp + 1'b1;
   end

   logic [HCR_W-1:0] cr_nph_q, cr_cplh_q;
   logic [DCR_W-1:0] cr_pd_q, cr_cpld_q;
   logic             cr_done;

   tlmon_credit_cap #(.HCR_W(HCR_W), .DCR_W(DCR_W)) u_cred (
      .clk(clk), .rst_n(rst_n), .init(cr_init),
      .nph(cr_nph), .pd(cr_pd), .cplh(cr_cplh), .cpld(cr_cpld),
      .nph_q(cr_nph_q), .pd_q(cr_pd_q), .cplh_q(cr_cplh_q), .cpld_q(cr_cpld_q),
      .done(cr_done)
   );

   // register image
   logic [NUM_REGS-1:0][REG_W-1:0] regv;
   always_comb begin
      regv = '0;
      for (int d = 0; d < NUM_DIR; d++) begin
         regv[int'(RG_UP_BEAT) + d][BEAT_W-1:0]           = beat_snap[d];
         regv[int'(RG_UP_WR) + 2*d][SMP_W +: BYTE_W]      = wr_snap[d];
         regv[int'(RG_UP_WR) + 2*d][SMP_W-1:0]            = smp;
         regv[int'(RG_UP_CPL) + 2*d][SMP_W +: BYTE_W]     = cpl_snap[d];
         regv[int'(RG_UP_CPL) + 2*d][SMP_W-1:0]           = smp;
      end
      regv[RG_CR_NPH][HCR_W-1:0]  = cr_nph_q;
      regv[RG_CR_PD][DCR_W-1:0]   = cr_pd_q;
      regv[RG_CR_CPLH][HCR_W-1:0] = cr_cplh_q;
      regv[RG_CR_CPLD][DCR_W-1:0] = cr_cpld_q;
   end

   // address decode
   logic [IDX_W-1:0] idx;
   logic             hit;
   assign idx = rd_addr[2 +: IDX_W];
   assign hit = (rd_addr[1:0] == 2'b00)
             && (rd_addr[ADDR_W-1:IDX_W+2] == '0)
             && (idx < IDX_W'(NUM_REGS));
   assign rd_data = hit ? regv[idx] : '0;
endmodule

// File: rtl/tl_traffic_mon_chk.sv
`timescale 1ns/1ps
module tl_traffic_mon_chk #(
   parameter int BEAT_W = 32,
   parameter int BYTE_W = 30,
   parameter int HCR_W  = 8,
   parameter int DCR_W  = 12,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [1:0]        smp,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [31:0]       rd_data,
   input logic [BEAT_W-1:0] up_beat,
   input logic [BYTE_W-1:0] up_wr,
   input logic              cr_done,
   input logic [HCR_W-1:0]  cr_nph,
   input logic [DCR_W-1:0]  cr_pd,
   input logic [HCR_W-1:0]  cr_cplh,
   input logic [DCR_W-1:0]  cr_cpld
);
   // R2: snapshots move only on a tick
   a_r2_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(up_beat) && $stable(up_wr)));

   // R5: sample number advances by one per tick
   a_r5_smp_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (smp == 2'($past(smp) + 2'd1)));

   // R5: sample number is visible in the low bits of a byte-count read
   a_r5_smp_field: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(8)) |-> (rd_data[1:0] == smp));

   // R7: captured credits never change
   a_r7_cred_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cr_done |=> (cr_done && $stable(cr_nph) && $stable(cr_pd)
                   && $stable(cr_cplh) && $stable(cr_cpld)));

   // R8: misaligned or unmapped addresses read zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_addr[1:0] != 2'b00) || (rd_addr >= ADDR_W'(40))) |-> (rd_data == 32'd0));

   // R8: header-credit register has no bits above its field
   a_r8_cred_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(24)) |-> (rd_data[31:HCR_W] == '0));
endmodule

bind tl_traffic_mon tl_traffic_mon_chk #(
   .BEAT_W(BEAT_W), .BYTE_W(BYTE_W), .HCR_W(HCR_W), .DCR_W(DCR_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_1s), .smp(smp),
   .rd_addr(rd_addr), .rd_data(rd_data),
   .up_beat(beat_snap[0]), .up_wr(wr_snap[0]),
   .cr_done(cr_done), .cr_nph(cr_nph_q), .cr_pd(cr_pd_q),
   .cr_cplh(cr_cplh_q), .cr_cpld(cr_cpld_q)
);

// File: tb/tl_traffic_mon_test.sv
`timescale 1ns/1ps
module tl_traffic_mon_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  bv = '0, br = '0, bl = '0;
   logic [1:0][1:0]  bk = '0;
   logic [1:0][10:0] blen = '0;
   logic        cr_init = 1'b0;
   logic [7:0]  cr_nph = '0, cr_cplh = '0;
   logic [11:0] cr_pd = '0, cr_cpld = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data, rd_data_s;

   int total = 0, fails = 0, ntick = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tl_traffic_mon uut (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick),
      .up_valid(bv[0]), .up_ready(br[0]), .up_last(bl[0]), .up_kind(bk[0]), .up_len(blen[0]),
      .dn_valid(bv[1]), .dn_ready(br[1]), .dn_last(bl[1]), .dn_kind(bk[1]), .dn_len(blen[1]),
      .cr_init(cr_init), .cr_nph(cr_nph), .cr_pd(cr_pd), .cr_cplh(cr_cplh), .cr_cpld(cr_cpld),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // narrow byte field so saturation is reachable
   tl_traffic_mon #(.BYTE_W(8), .LEN_W(8)) uut_small (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick),
      .up_valid(bv[0]), .up_ready(br[0]), .up_last(bl[0]), .up_kind(bk[0]), .up_len(blen[0][7:0]),
      .dn_valid(bv[1]), .dn_ready(br[1]), .dn_last(bl[1]), .dn_kind(bk[1]), .dn_len(blen[1][7:0]),
      .cr_init(cr_init), .cr_nph(cr_nph), .cr_pd(cr_pd), .cr_cplh(cr_cplh), .cr_cpld(cr_cpld),
      .rd_addr(rd_addr), .rd_data(rd_data_s)
   );

   function automatic logic [31:0] bc(int units);
      return (32'(units) << 2) | 32'(ntick % 4);
   endfunction

   task automatic chk(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      total++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
      end
   endtask

   task automatic chk_s(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      total++;
      if (rd_data_s !== exp) begin
         fails++;
         $display("FAIL %s narrow addr=%h actual=%h expected=%h", tag, a, rd_data_s, exp);
      end
   endtask

   task automatic xfer(int d, logic [1:0] k, int len, int n, bit stall);
      for (int i = 0; i < n; i++) begin
         if (stall && i == 1) begin
            @(negedge clk); bv[d] = 1'b1; br[d] = 1'b0; bl[d] = 1'b0;
            @(negedge clk); bv[d] = 1'b0; br[d] = 1'b1;
         end
         @(negedge clk);
         bv[d] = 1'b1; br[d] = 1'b1; bl[d] = (i == n-1);
         bk[d] = k; blen[d] = 11'(len);
      end
      @(negedge clk);
      bv[d] = 1'b0; br[d] = 1'b0; bl[d] = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      ntick++;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 40; a += 4) chk(8'(a), 32'd0, "R8 reset value");
      chk(8'h28, 32'd0, "R8 unmapped");
      chk(8'h09, 32'd0, "R8 misaligned");
   endtask

   task automatic t_basic();
      xfer(0, 2'd1, 20, 3, 1'b1);
      xfer(1, 2'd2, 8, 2, 1'b0);
      pulse_tick();
      chk(8'h00, 32'd3, "R1 upstream beats with stall");
      chk(8'h04, 32'd2, "R1 downstream beats");
      chk(8'h08, bc(20), "R3 upstream write payload");
      chk(8'h0C, bc(0), "R4 upstream completion empty");
      chk(8'h10, bc(0), "R4 downstream write empty");
      chk(8'h14, bc(8), "R4 downstream completion payload");
   endtask

   task automatic t_window();
      xfer(0, 2'd0, 0, 2, 1'b0);
      @(negedge clk);
      tick = 1'b1; bv[0] = 1'b1; br[0] = 1'b1; bl[0] = 1'b1; bk[0] = 2'd0; blen[0] = '0;
      @(negedge clk);
      tick = 1'b0; bv[0] = 1'b0; br[0] = 1'b0; bl[0] = 1'b0;
      ntick++;
      chk(8'h00, 32'd2, "R2 tick-cycle beat excluded");
      chk(8'h08, bc(0), "R2 byte count restarted");
      pulse_tick();
      chk(8'h00, 32'd1, "R2 tick-cycle beat in next window");
      chk(8'h04, 32'd0, "R2 idle direction zero");
   endtask

   task automatic t_kinds();
      xfer(0, 2'd2, 5, 1, 1'b0);
      xfer(1, 2'd1, 7, 3, 1'b0);
      xfer(0, 2'd3, 50, 1, 1'b0);
      xfer(0, 2'd0, 40, 1, 1'b0);
      pulse_tick();
      chk(8'h0C, bc(5), "R4 upstream completion");
      chk(8'h10, bc(7), "R3 length taken from first beat only");
      chk(8'h08, bc(0), "R3 other kinds ignored, R5 sample wrap");
      chk(8'h00, 32'd3, "R1 upstream beats");
      chk(8'h04, 32'd3, "R1 downstream beats");
   endtask

   task automatic t_sat();
      xfer(0, 2'd1, 200, 2, 1'b0);
      xfer(0, 2'd1, 100, 1, 1'b0);
      pulse_tick();
      chk(8'h08, bc(300), "R6 wide field no saturation");
      chk_s(8'h08, bc(255), "R6 narrow field saturates");
      pulse_tick();
      chk_s(8'h08, bc(0), "R6 restart after saturation");
      chk(8'h14, bc(0), "R5 sample number in completion register");
   endtask

   task automatic t_credit();
      @(negedge clk);
      cr_init = 1'b1; cr_nph = 8'h2A; cr_pd = 12'h5C3; cr_cplh = 8'h11; cr_cpld = 12'hABC;
      @(negedge clk);
      cr_init = 1'b0;
      chk(8'h18, 32'h2A, "R7 nph captured");
      chk(8'h1C, 32'h5C3, "R7 pd captured");
      chk(8'h20, 32'h11, "R7 cplh captured");
      chk(8'h24, 32'hABC, "R7 cpld captured");
      @(negedge clk);
      cr_init = 1'b1; cr_nph = 8'hFF; cr_pd = 12'h001; cr_cplh = 8'h77; cr_cpld = 12'h123;
      @(negedge clk);
      cr_init = 1'b0;
      chk(8'h18, 32'h2A, "R7 second strobe ignored nph");
      chk(8'h1C, 32'h5C3, "R7 second strobe ignored pd");
      chk(8'h20, 32'h11, "R7 second strobe ignored cplh");
      chk(8'h24, 32'hABC, "R7 second strobe ignored cpld");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_window();
      t_kinds();
      t_sat();
      t_credit();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL R2 watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule